// File: doc/BRIEF.md
# Divided Output Clock with Fine and Coarse Phase Shift

This block is the digital output stage of a clock synthesizer. It receives eight copies of a fast oscillator clock, each shifted from the previous one by one eighth of the oscillator period. It produces one divided output clock. The output can be shifted in two ways. The fine shift picks which of the eight phase copies drives the output counter, in steps of 45 degrees. The coarse shift holds off the first output edge by a whole number of oscillator periods.

The configuration has three values: a tap index, a start-delay value S and a divide ratio N. All three are captured only while reset is asserted, so each reset release starts a fresh, deterministic alignment. After release, the first output rising edge lands on the selected phase copy, S−1 oscillator periods after the first edge of that copy. From then on the output repeats every N oscillator periods.

Several instances fed from the same phase bundle, each with its own tap and delay, produce outputs with distinct and predictable relative skews.

Top module: `pll_postscale_shifter`

## Requirements
- R1: With S = 1, the first output rising edge coincides with the first rising edge of the selected phase input (`vco_taps[tap_sel]`) after reset is released. Tap k lags tap 0 by k/8 of the oscillator period.
- R2: With S greater than 1, the first output rising edge is delayed by exactly S−1 further oscillator periods beyond the R1 edge.
- R3: A start-delay value of 0 behaves exactly like 1.
- R4: For 2 ≤ N ≤ 512 the output period is N oscillator periods. The high time is ceil(N/2) periods and the low time is floor(N/2) periods.
- R5: N = 1 outputs the selected phase input itself (half-period high). N = 0 is treated as 1, and any N above 512 is treated as 512.
- R6: While reset is asserted the output is held low.
- R7: Tap index, start delay and divide ratio are captured only while reset is high. Changes made while running have no effect on the output until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_taps | input | 8 | Oscillator phase copies; bit k lags bit 0 by k/8 period |
| rst | input | 1 | Asynchronous active-high reset; configuration is captured while high |
| div_ratio | input | 10 | Divide ratio N |
| tap_sel | input | 3 | Index of the phase copy that clocks the counter |
| init_dly | input | 8 | Start-delay value S |
| clk_out | output | 1 | Divided, phase-shifted output clock |

## Verification
The hardest situation to reach is a configuration change while the counter is running. That change must be provably ignored, yet it must take effect after the next reset. The stimulus starts a run, lets the output settle, and then rewrites all three settings mid-run. It confirms that the output period and edge phase are unchanged. It then pulses reset and confirms that the new first-edge time and period match the new settings. The edge timing itself is measured against the tap-0 edge at which reset was released. Each combination of fine tap and coarse delay therefore maps to one exact expected time offset.

// File: rtl/pll_postscale_shifter.sv
`timescale 1ns/1ps
module pll_postscale_shifter #(
  parameter int NUM_TAPS = 8,
  parameter int DIV_W    = 10,
  parameter int MAX_DIV  = 512,
  parameter int DLY_W    = 8,
  localparam int SEL_W   = $clog2(NUM_TAPS)
) (
  input  logic [NUM_TAPS-1:0] vco_taps,
  input  logic                rst,
  input  logic [DIV_W-1:0]    div_ratio,
  input  logic [SEL_W-1:0]    tap_sel,
  input  logic [DLY_W-1:0]    init_dly,
  output logic                clk_out
);

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] n);
    if (n == '0) return DIV_W'(1);
    if (n > DIV_W'(MAX_DIV)) return DIV_W'(MAX_DIV);
    return n;
  endfunction

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge vco_taps[0])
    if (rst) begin
      sel_q <= tap_sel;
      div_q <= clamp_div(div_ratio);
      dly_q <= (init_dly == '0) ? DLY_W'(1) : init_dly;
    end

  logic sel_clk;
  assign sel_clk = vco_taps[sel_q];

  logic [DIV_W-1:0] hi_len, lo_len;
  logic             bypass;
  assign hi_len = (div_q >> 1) + {{(DIV_W-1){1'b0}}, div_q[0]};
  assign lo_len = div_q >> 1;
  assign bypass = (div_q == DIV_W'(1));

  logic             run, out_q;
  logic [DLY_W-1:0] dcnt;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge sel_clk or posedge rst)
    if (rst) begin
      run   <= 1'b0;
      out_q <= 1'b0;
      dcnt  <= '0;
      cnt   <= '0;
    end else if (!run) begin
      if (dcnt == dly_q - DLY_W'(1)) begin
        run   <= 1'b1;
        out_q <= 1'b1;
        cnt   <= hi_len - DIV_W'(1);
      end else begin
        dcnt <= dcnt + DLY_W'(1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - DIV_W'(1);
    end else if (out_q) begin
      out_q <= 1'b0;
      cnt   <= (lo_len == '0) ? '0 : lo_len - DIV_W'(1);
    end else begin
      out_q <= 1'b1;
      cnt   <= hi_len - DIV_W'(1);
    end

  assign clk_out = bypass ? (run & sel_clk) : out_q;

  p_low_in_reset_r6: assert property (@(posedge vco_taps[0]) rst |-> !clk_out);

  p_quiet_until_start_r2: assert property (@(posedge sel_clk) disable iff (rst)
    !run |-> !clk_out);

  p_high_bound_r4: assert property (@(posedge sel_clk) disable iff (rst)
    (run && out_q) |-> (cnt < hi_len));

  p_low_bound_r4: assert property (@(posedge sel_clk) disable iff (rst)
    (run && !out_q && lo_len != '0) |-> (cnt < lo_len));

  p_flip_on_expiry_r4: assert property (@(posedge sel_clk) disable iff (rst)
    (run && cnt == '0 && !bypass) |=> (out_q != $past(out_q)));

  p_cfg_frozen_r7: assert property (@(posedge vco_taps[0]) disable iff (rst)
    $past(!rst) |-> ($stable(sel_q) && $stable(div_q) && $stable(dly_q)));

endmodule

// File: tb/pll_postscale_shifter_tb.sv
`timescale 1ns/1ps
module pll_postscale_shifter_tb;
  localparam int T_VCO = 16;
  localparam int NV = 10;
  // {tap, S, N}
  localparam int VEC [NV][3] = '{
    '{0, 1, 2}, '{3, 1, 4}, '{7, 1, 3}, '{0, 3, 4}, '{5, 3, 5},
    '{2, 0, 6}, '{4, 2, 1}, '{6, 1, 0}, '{1, 4, 7}, '{0, 1, 600}
  };

  logic [7:0] taps;
  logic       rst;
  logic [9:0] div_ratio;
  logic [2:0] tap_sel;
  logic [7:0] init_dly;
  logic       clk_out;
  int checks = 0, fails = 0;
  longint tb0, r1, f1, r2;

  for (genvar k = 0; k < 8; k++) begin : g_tap
    logic t;
    initial begin
      t = 1'b0;
      #(k * T_VCO / 8);
      forever #(T_VCO / 2) t = ~t;
    end
    assign taps[k] = t;
  end

  pll_postscale_shifter u_dut (
    .vco_taps(taps), .rst(rst), .div_ratio(div_ratio),
    .tap_sel(tap_sel), .init_dly(init_dly), .clk_out(clk_out));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int k, input int s, input int n);
    int se, ne;
    string tf, tp;
    se = (s == 0) ? 1 : s;
    ne = (n == 0) ? 1 : (n > 512 ? 512 : n);
    tf = (s == 0) ? "R3" : (s > 1 ? "R2" : "R1");
    tp = (n <= 1 || n > 512) ? "R5" : "R4";
    #3 rst = 1'b1;
    tap_sel = 3'(k); init_dly = 8'(s); div_ratio = 10'(n);
    repeat (3) @(posedge taps[0]);
    #1 check("R6", longint'(clk_out), 0);
    @(posedge taps[0]);
    tb0 = $time;
    #1 rst = 1'b0;
    @(posedge clk_out) r1 = $time;
    @(negedge clk_out) f1 = $time;
    @(posedge clk_out) r2 = $time;
    check(tf, r1 - tb0, longint'((k == 0 ? T_VCO : 2 * k) + (se - 1) * T_VCO));
    check(tp, f1 - r1, longint'(ne == 1 ? T_VCO / 2 : ((ne + 1) / 2) * T_VCO));
    check(tp, r2 - r1, longint'(ne * T_VCO));
  endtask

  initial begin
    #(40000 * T_VCO);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint ra, rb;
    rst = 1'b1; tap_sel = '0; init_dly = 8'd1; div_ratio = 10'd2;
    repeat (2) @(posedge taps[0]);
    #1 check("R6", longint'(clk_out), 0);

    for (int i = 0; i < NV; i++) run_case(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R7: mid-run configuration change is ignored
    run_case(2, 2, 4);
    #3 tap_sel = 3'd5; init_dly = 8'd7; div_ratio = 10'd9;
    @(posedge clk_out) ra = $time;
    @(posedge clk_out) rb = $time;
    check("R7", rb - ra, longint'(4 * T_VCO));
    check("R7", (ra - r1) % (4 * T_VCO), 0);
    // R7: the new values take effect after the next reset
    run_case(5, 7, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule